// File: doc/BRIEF.md
# Memory Error Status and Log Capture

This block keeps the sticky event flags of a memory controller, and a small log that describes the failing read of the most recent ECC error worth keeping. The read path reports single-bit (corrected) and multi-bit (uncorrectable) errors as one-cycle pulses. Each pulse comes with the address, channel, device and syndrome of that read. Other pulses report a thermal trip, a DRAM throttle condition, a lock cycle aimed at memory outside DRAM and a software event. Software reads the 16-bit status word and the log through plain outputs. It clears flags by writing ones on a one-cycle write strobe.

A three-state log machine decides when the log is captured. In `LOG_OPEN` no ECC flag is set and the log accepts any error. In `LOG_SB_HELD` a single-bit error is held; only a multi-bit error may replace it. In `LOG_MB_HELD` a multi-bit error is held and nothing replaces it. The named transitions are:
- `OPEN->SB`: a single-bit error with no multi-bit error.
- `OPEN->MB` and `SB->MB`: a multi-bit error.
- `SB->OPEN`: software clears the single-bit flag.
- `MB->SB`: software clears the multi-bit flag while the single-bit flag stays set.
- `MB->OPEN`: software clears both flags.

A thermal trip is routed to exactly one of three interrupt kinds. When the trip is routed, the block raises a one-cycle message request. Every flag and the log survive the core reset and are cleared only by the power-good reset.

Top module: `mem_err_status`

## Requirements
- R1: While `pwrgood_rst_n` is low, all flags, all log fields, `msg_req` and `msg_kind` are zero.
- R2: Each event pulse sets its flag in `status_rd`, visible after the next rising clock edge. The flags sit at fixed bits: single-bit ECC at bit 0, multi-bit ECC at bit 1, throttle at bit 7, lock-to-non-DRAM at bit 9, thermal at bit 11 and software event at bit 12.
- R3: Bits 15:13, 10, 8 and 6:2 of `status_rd` always read 0, and writing ones to them changes nothing.
- R4: A write with `wr_en` high clears each flag whose bit in `wr_data` is 1. Flags whose bit in `wr_data` is 0 keep their value.
- R5: Asserting `core_rst_n` low leaves the flags and the log unchanged. It forces `msg_req` to 0.
- R6: A single-bit error in `LOG_OPEN` has these effects:
  - it captures `err_addr` and `err_dev` into the log;
  - it leaves the channel and syndrome log fields unchanged;
  - while the single-bit flag stays set, later single-bit errors do not change the log.
- R7: A multi-bit error in `LOG_OPEN` or `LOG_SB_HELD` sets bit 1 and captures the address, channel, device and syndrome into the log. This overwrites a held single-bit entry.
- R8: In `LOG_MB_HELD` no error changes the log. A single-bit error in this state still sets bit 0.
- R9: If single-bit and multi-bit errors arrive in the same cycle, both flags are set and the multi-bit signature is logged.
- R10: If a hardware set and a software clear of the same flag fall in the same cycle, the flag ends at 1.
- R11: A thermal trip has these effects when the thermal flag is clear and exactly one of `route_en` bits is set (bit 0 SMI, bit 1 SCI, bit 2 SERR):
  - it sets bit 11;
  - after the next edge, `msg_req` is high for exactly one cycle;
  - `msg_kind` is 1 for SMI, 2 for SCI and 3 for SERR, and 0 when no request is pending.
- R12: A thermal trip sets no flag and sends no message in either of these cases:
  - `route_en` has zero bits or more than one bit set;
  - the thermal flag is already set.
- R13: Clearing the multi-bit flag while the single-bit flag stays set leaves the log held against single-bit updates. Once both flags are clear, the next single-bit error captures again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwrgood_rst_n | input | 1 | Power-good reset, async, active low; clears all state |
| core_rst_n | input | 1 | Core reset, async, active low; clears only the message output |
| sb_err | input | 1 | Single-bit ECC error pulse |
| mb_err | input | 1 | Multi-bit ECC error pulse |
| err_addr | input | ADDR_W | Address of the failing read |
| err_chan | input | CHAN_W | Channel of the failing read |
| err_dev | input | DEV_W | Device of the failing read |
| err_syn | input | SYN_W | Syndrome of the failing read |
| thermal_trip | input | 1 | Thermal trip pulse |
| route_en | input | 3 | One-hot route select: bit 0 SMI, bit 1 SCI, bit 2 SERR |
| throttle_evt | input | 1 | DRAM throttle event pulse |
| lock_evt | input | 1 | Lock to non-DRAM memory event pulse |
| sw_evt | input | 1 | Software event pulse |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 16 | Write-one-to-clear mask |
| status_rd | output | 16 | Status word |
| log_addr | output | ADDR_W | Logged address |
| log_chan | output | CHAN_W | Logged channel |
| log_dev | output | DEV_W | Logged device |
| log_syn | output | SYN_W | Logged syndrome |
| msg_req | output | 1 | One-cycle interrupt message request |
| msg_kind | output | 2 | Message kind: 1 SMI, 2 SCI, 3 SERR, 0 none |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a software clear and a hardware set of the same flag. The bench provokes it by raising a write strobe that clears bits 0 and 1 together with a multi-bit error pulse. It also writes the throttle bit in the same cycle as a throttle pulse. It judges that the flag that was set again stays 1 while its neighbour clears. It also judges that the log does not recapture while the machine sits in `LOG_MB_HELD`.

The second pair is a single-bit and a multi-bit error in one cycle. The bench provokes it with both pulses and distinct address, channel, device and syndrome values. It judges that both flags rise and the multi-bit values are the ones logged.

// File: rtl/mes_pkg.sv
package mes_pkg;

    localparam int STAT_W = 16;
    localparam int NFLAG  = 6;

    // flag bank indices
    localparam int FL_SB  = 0;
    localparam int FL_MB  = 1;
    localparam int FL_THR = 2;
    localparam int FL_LCK = 3;
    localparam int FL_THM = 4;
    localparam int FL_SWE = 5;

    typedef enum logic [1:0] {
        LOG_OPEN    = 2'd0,
        LOG_SB_HELD = 2'd1,
        LOG_MB_HELD = 2'd2
    } log_state_e;

    typedef enum logic [1:0] {
        MSG_NONE = 2'd0,
        MSG_SMI  = 2'd1,
        MSG_SCI  = 2'd2,
        MSG_SERR = 2'd3
    } msg_kind_e;

    // status word bit position of each flag bank entry
    function automatic int flag_pos(input int idx);
        case (idx)
            FL_SB:   return 0;
            FL_MB:   return 1;
            FL_THR:  return 7;
            FL_LCK:  return 9;
            FL_THM:  return 11;
            default: return 12;
        endcase
    endfunction

endpackage

// File: rtl/mes_flag_bank.sv
module mes_flag_bank #(
    parameter int NF = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_i,
    input  logic [NF-1:0] clr_i,
    output logic [NF-1:0] flags_o,
    output logic [NF-1:0] flags_next_o
);

    generate
        for (genvar i = 0; i < NF; i++) begin : g_flag
            // set dominates clear
            assign flags_next_o[i] = set_i[i] | (flags_o[i] & ~clr_i[i]);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) flags_o[i] <= 1'b0;
                else        flags_o[i] <= flags_next_o[i];
            end

            assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
                set_i[i] |=> flags_o[i]);

            assert_clear_works_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i[i] && !set_i[i]) |=> !flags_o[i]);
        end
    endgenerate

endmodule

// File: rtl/mes_err_log.sv
module mes_err_log
    import mes_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CHAN_W = 1,
    parameter int DEV_W  = 2,
    parameter int SYN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sb_evt_i,
    input  logic              mb_evt_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CHAN_W-1:0] chan_i,
    input  logic [DEV_W-1:0]  dev_i,
    input  logic [SYN_W-1:0]  syn_i,
    input  logic              sb_next_i,
    input  logic              mb_next_i,
    output logic [ADDR_W-1:0] log_addr_o,
    output logic [CHAN_W-1:0] log_chan_o,
    output logic [DEV_W-1:0]  log_dev_o,
    output logic [SYN_W-1:0]  log_syn_o
);

    log_state_e state_q, state_d;
    logic       cap_mb, cap_sb;

    assign cap_mb = mb_evt_i && (state_q != LOG_MB_HELD);
    assign cap_sb = sb_evt_i && !mb_evt_i && (state_q == LOG_OPEN);

    always_comb begin
        state_d = state_q;
        if (cap_mb) begin
            state_d = LOG_MB_HELD;
        end else if (cap_sb) begin
            state_d = LOG_SB_HELD;
        end else begin
            unique case (state_q)
                LOG_OPEN:    state_d = LOG_OPEN;
                LOG_SB_HELD: if (!sb_next_i) state_d = LOG_OPEN;
                LOG_MB_HELD: if (!mb_next_i) state_d = sb_next_i ? LOG_SB_HELD : LOG_OPEN;
                default:     state_d = LOG_OPEN;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LOG_OPEN;
        else        state_q <= state_d;
    end

    // log outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            log_addr_o <= '0;
            log_chan_o <= '0;
            log_dev_o  <= '0;
            log_syn_o  <= '0;
        end else if (cap_mb) begin
            log_addr_o <= addr_i;
            log_chan_o <= chan_i;
            log_dev_o  <= dev_i;
            log_syn_o  <= syn_i;
        end else if (cap_sb) begin
            log_addr_o <= addr_i;
            log_dev_o  <= dev_i;
        end
    end

    assert_mb_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_evt_i && state_q != LOG_MB_HELD) |=>
            (log_addr_o == $past(addr_i) && log_syn_o == $past(syn_i)));

    assert_mb_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LOG_MB_HELD) |=> ($stable(log_addr_o) && $stable(log_syn_o)));

    assert_sb_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LOG_SB_HELD && !mb_evt_i) |=> $stable(log_addr_o));

    assert_sb_keeps_syn_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mb_evt_i |=> $stable(log_syn_o));

endmodule

// File: rtl/mes_therm_route.sv
module mes_therm_route
    import mes_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trip_i,
    input  logic [2:0] route_en_i,
    input  logic       flag_i,
    output logic       set_o,
    output logic       msg_req_o,
    output logic [1:0] msg_kind_o
);

    logic      route_ok;
    msg_kind_e kind_d;

    always_comb begin
        route_ok = 1'b1;
        kind_d   = MSG_NONE;
        unique case (route_en_i)
            3'b001:  kind_d = MSG_SMI;
            3'b010:  kind_d = MSG_SCI;
            3'b100:  kind_d = MSG_SERR;
            default: route_ok = 1'b0;
        endcase
    end

    assign set_o = trip_i && route_ok && !flag_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msg_req_o  <= 1'b0;
            msg_kind_o <= MSG_NONE;
        end else begin
            msg_req_o  <= set_o;
            msg_kind_o <= set_o ? kind_d : MSG_NONE;
        end
    end

    assert_msg_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        msg_req_o |=> !msg_req_o);

    assert_msg_valid_route_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_req_o) |-> $past(trip_i && !flag_i && $onehot(route_en_i)));

endmodule

// File: rtl/mem_err_status.sv
module mem_err_status
    import mes_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CHAN_W = 1,
    parameter int DEV_W  = 2,
    parameter int SYN_W  = 8
) (
    input  logic              clk,
    input  logic              pwrgood_rst_n,
    input  logic              core_rst_n,
    input  logic              sb_err,
    input  logic              mb_err,
    input  logic [ADDR_W-1:0] err_addr,
    input  logic [CHAN_W-1:0] err_chan,
    input  logic [DEV_W-1:0]  err_dev,
    input  logic [SYN_W-1:0]  err_syn,
    input  logic              thermal_trip,
    input  logic [2:0]        route_en,
    input  logic              throttle_evt,
    input  logic              lock_evt,
    input  logic              sw_evt,
    input  logic              wr_en,
    input  logic [15:0]       wr_data,
    output logic [15:0]       status_rd,
    output logic [ADDR_W-1:0] log_addr,
    output logic [CHAN_W-1:0] log_chan,
    output logic [DEV_W-1:0]  log_dev,
    output logic [SYN_W-1:0]  log_syn,
    output logic              msg_req,
    output logic [1:0]        msg_kind
);

    logic [NFLAG-1:0] set_vec, clr_vec, flags, flags_nx;
    logic             therm_set;
    logic             msg_rst_n;

    assign msg_rst_n = pwrgood_rst_n & core_rst_n;

    assign set_vec[FL_SB]  = sb_err;
    assign set_vec[FL_MB]  = mb_err;
    assign set_vec[FL_THR] = throttle_evt;
    assign set_vec[FL_LCK] = lock_evt;
    assign set_vec[FL_THM] = therm_set;
    assign set_vec[FL_SWE] = sw_evt;

    generate
        for (genvar i = 0; i < NFLAG; i++) begin : g_map
            assign clr_vec[i] = wr_en & wr_data[flag_pos(i)];
        end
    endgenerate

    always_comb begin
        status_rd = '0;
        for (int i = 0; i < NFLAG; i++) status_rd[flag_pos(i)] = flags[i];
    end

    mes_flag_bank #(.NF(NFLAG)) u_flags (
        .clk          (clk),
        .rst_n        (pwrgood_rst_n),
        .set_i        (set_vec),
        .clr_i        (clr_vec),
        .flags_o      (flags),
        .flags_next_o (flags_nx)
    );

    mes_err_log #(
        .ADDR_W (ADDR_W),
        .CHAN_W (CHAN_W),
        .DEV_W  (DEV_W),
        .SYN_W  (SYN_W)
    ) u_log (
        .clk        (clk),
        .rst_n      (pwrgood_rst_n),
        .sb_evt_i   (sb_err),
        .mb_evt_i   (mb_err),
        .addr_i     (err_addr),
        .chan_i     (err_chan),
        .dev_i      (err_dev),
        .syn_i      (err_syn),
        .sb_next_i  (flags_nx[FL_SB]),
        .mb_next_i  (flags_nx[FL_MB]),
        .log_addr_o (log_addr),
        .log_chan_o (log_chan),
        .log_dev_o  (log_dev),
        .log_syn_o  (log_syn)
    );

    mes_therm_route u_therm (
        .clk        (clk),
        .rst_n      (msg_rst_n),
        .trip_i     (thermal_trip),
        .route_en_i (route_en),
        .flag_i     (flags[FL_THM]),
        .set_o      (therm_set),
        .msg_req_o  (msg_req),
        .msg_kind_o (msg_kind)
    );

    assert_sb_sets_R2: assert property (@(posedge clk) disable iff (!pwrgood_rst_n)
        sb_err |=> status_rd[0]);

    assert_msg_has_flag_R11: assert property (@(posedge clk) disable iff (!pwrgood_rst_n)
        msg_req |-> status_rd[11]);

endmodule

// File: tb/mem_err_status_tb.sv
module mem_err_status_tb_top;

    typedef struct {
        int          tgt;
        logic [15:0] st;
        logic [31:0] addr;
        logic        chan;
        logic [1:0]  dev;
        logic [7:0]  syn;
        logic        msg;
        logic [1:0]  kind;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        pwrgood_rst_n, core_rst_n;
    logic        sb_err, mb_err, thermal_trip, throttle_evt, lock_evt, sw_evt, wr_en;
    logic [31:0] err_addr;
    logic        err_chan;
    logic [1:0]  err_dev;
    logic [7:0]  err_syn;
    logic [2:0]  route_en;
    logic [15:0] wr_data;
    logic [15:0] status_rd;
    logic [31:0] log_addr;
    logic        log_chan;
    logic [1:0]  log_dev;
    logic [7:0]  log_syn;
    logic        msg_req;
    logic [1:0]  msg_kind;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    exp_t q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mem_err_status dut_i (
        .clk(clk), .pwrgood_rst_n(pwrgood_rst_n), .core_rst_n(core_rst_n),
        .sb_err(sb_err), .mb_err(mb_err), .err_addr(err_addr), .err_chan(err_chan),
        .err_dev(err_dev), .err_syn(err_syn), .thermal_trip(thermal_trip),
        .route_en(route_en), .throttle_evt(throttle_evt), .lock_evt(lock_evt),
        .sw_evt(sw_evt), .wr_en(wr_en), .wr_data(wr_data), .status_rd(status_rd),
        .log_addr(log_addr), .log_chan(log_chan), .log_dev(log_dev), .log_syn(log_syn),
        .msg_req(msg_req), .msg_kind(msg_kind)
    );

    task automatic idle_inputs();
        sb_err = 0; mb_err = 0; thermal_trip = 0; throttle_evt = 0;
        lock_evt = 0; sw_evt = 0; wr_en = 0; wr_data = '0; route_en = 3'b000;
    endtask

    task automatic set_err(input logic [31:0] a, input logic c, input logic [1:0] d,
                           input logic [7:0] s);
        err_addr = a; err_chan = c; err_dev = d; err_syn = s;
    endtask

    // driver: inputs are already applied; push expectation, run one cycle
    task automatic step(input logic [15:0] st, input logic [31:0] a, input logic c,
                        input logic [1:0] d, input logic [7:0] s, input logic m,
                        input logic [1:0] k, input string tag);
        exp_t e;
        e.tgt = cyc + 1; e.st = st; e.addr = a; e.chan = c; e.dev = d;
        e.syn = s; e.msg = m; e.kind = k; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        idle_inputs();
    endtask

    // monitor: compares results in the cycle they are due
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].tgt == cyc) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (status_rd !== e.st || log_addr !== e.addr || log_chan !== e.chan ||
                log_dev !== e.dev || log_syn !== e.syn || msg_req !== e.msg ||
                msg_kind !== e.kind) begin
                n_bad++;
                $display("FAIL %s: got st=%h addr=%h ch=%0d dev=%0d syn=%h msg=%0d kind=%0d exp st=%h addr=%h ch=%0d dev=%0d syn=%h msg=%0d kind=%0d",
                    e.tag, status_rd, log_addr, log_chan, log_dev, log_syn, msg_req, msg_kind,
                    e.st, e.addr, e.chan, e.dev, e.syn, e.msg, e.kind);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        idle_inputs();
        set_err(32'h0, 1'b0, 2'd0, 8'h00);
        pwrgood_rst_n = 0; core_rst_n = 0;
        repeat (3) @(negedge clk);
        pwrgood_rst_n = 1; core_rst_n = 1;

        step(16'h0000, 32'h0, 0, 0, 8'h00, 0, 0, "R1 reset state");

        sb_err = 1; set_err(32'h1000_0040, 1, 2, 8'h5A);
        step(16'h0001, 32'h1000_0040, 0, 2, 8'h00, 0, 0, "R6 first single-bit capture");
        sb_err = 1; set_err(32'h2000_0080, 0, 3, 8'h11);
        step(16'h0001, 32'h1000_0040, 0, 2, 8'h00, 0, 0, "R6 second single-bit held");

        mb_err = 1; set_err(32'h3000_00C0, 1, 1, 8'hC3);
        step(16'h0003, 32'h3000_00C0, 1, 1, 8'hC3, 0, 0, "R7 multi-bit overwrites");
        sb_err = 1; set_err(32'h4000_0000, 0, 0, 8'h22);
        step(16'h0003, 32'h3000_00C0, 1, 1, 8'hC3, 0, 0, "R8 single-bit while mb held");
        mb_err = 1; set_err(32'h5000_0000, 0, 2, 8'h33);
        step(16'h0003, 32'h3000_00C0, 1, 1, 8'hC3, 0, 0, "R8 multi-bit while mb held");

        wr_en = 1; wr_data = 16'h0000;
        step(16'h0003, 32'h3000_00C0, 1, 1, 8'hC3, 0, 0, "R4 write zero keeps flags");
        wr_en = 1; wr_data = 16'h0002;
        step(16'h0001, 32'h3000_00C0, 1, 1, 8'hC3, 0, 0, "R4 clear multi-bit only");
        sb_err = 1; set_err(32'h6000_0000, 0, 2, 8'h44);
        step(16'h0001, 32'h3000_00C0, 1, 1, 8'hC3, 0, 0, "R13 still held after mb clear");
        wr_en = 1; wr_data = 16'hFFFF;
        step(16'h0000, 32'h3000_00C0, 1, 1, 8'hC3, 0, 0, "R3 R4 write all ones");
        sb_err = 1; set_err(32'h7000_0000, 0, 3, 8'h77);
        step(16'h0001, 32'h7000_0000, 1, 3, 8'hC3, 0, 0, "R13 capture reopens");
        wr_en = 1; wr_data = 16'h0001;
        step(16'h0000, 32'h7000_0000, 1, 3, 8'hC3, 0, 0, "R4 clear single-bit");

        sb_err = 1; mb_err = 1; set_err(32'h8000_0010, 0, 2, 8'h99);
        step(16'h0003, 32'h8000_0010, 0, 2, 8'h99, 0, 0, "R9 both errors same cycle");
        wr_en = 1; wr_data = 16'h0003; mb_err = 1; set_err(32'h9000_0000, 1, 1, 8'h12);
        step(16'h0002, 32'h8000_0010, 0, 2, 8'h99, 0, 0, "R10 mb set beats clear");
        wr_en = 1; wr_data = 16'h0002;
        step(16'h0000, 32'h8000_0010, 0, 2, 8'h99, 0, 0, "R4 clear mb");

        throttle_evt = 1; lock_evt = 1; sw_evt = 1;
        step(16'h1280, 32'h8000_0010, 0, 2, 8'h99, 0, 0, "R2 throttle lock software bits");
        wr_en = 1; wr_data = 16'h1280; throttle_evt = 1;
        step(16'h0080, 32'h8000_0010, 0, 2, 8'h99, 0, 0, "R10 throttle set beats clear");
        wr_en = 1; wr_data = 16'h0080;
        step(16'h0000, 32'h8000_0010, 0, 2, 8'h99, 0, 0, "R4 clear throttle");

        thermal_trip = 1; route_en = 3'b010;
        step(16'h0800, 32'h8000_0010, 0, 2, 8'h99, 1, 2, "R11 thermal SCI message");
        step(16'h0800, 32'h8000_0010, 0, 2, 8'h99, 0, 0, "R11 message lasts one cycle");
        thermal_trip = 1; route_en = 3'b001;
        step(16'h0800, 32'h8000_0010, 0, 2, 8'h99, 0, 0, "R12 flag already set");
        wr_en = 1; wr_data = 16'h0800;
        step(16'h0000, 32'h8000_0010, 0, 2, 8'h99, 0, 0, "R4 clear thermal");
        thermal_trip = 1; route_en = 3'b011;
        step(16'h0000, 32'h8000_0010, 0, 2, 8'h99, 0, 0, "R12 two enables invalid");
        thermal_trip = 1; route_en = 3'b000;
        step(16'h0000, 32'h8000_0010, 0, 2, 8'h99, 0, 0, "R12 no enable");
        thermal_trip = 1; route_en = 3'b100;
        step(16'h0800, 32'h8000_0010, 0, 2, 8'h99, 1, 3, "R11 thermal SERR message");
        thermal_trip = 1; route_en = 3'b001; wr_en = 1; wr_data = 16'h0800;
        step(16'h0000, 32'h8000_0010, 0, 2, 8'h99, 0, 0, "R12 trip with flag set at edge");
        thermal_trip = 1; route_en = 3'b001;
        step(16'h0800, 32'h8000_0010, 0, 2, 8'h99, 1, 1, "R11 thermal SMI message");

        sw_evt = 1;
        step(16'h1800, 32'h8000_0010, 0, 2, 8'h99, 0, 0, "R2 software event");
        core_rst_n = 0;
        step(16'h1800, 32'h8000_0010, 0, 2, 8'h99, 0, 0, "R5 core reset keeps state");
        core_rst_n = 1;
        wr_en = 1; wr_data = 16'hE57C;
        step(16'h1800, 32'h8000_0010, 0, 2, 8'h99, 0, 0, "R3 reserved writes ignored");

        pwrgood_rst_n = 0;
        step(16'h0000, 32'h0, 0, 0, 8'h00, 0, 0, "R1 power-good clears all");
        pwrgood_rst_n = 1;
        @(negedge clk);

        if (q.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL scoreboard left %0d items, expected 0", q.size());
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule